// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block sits between an instruction sequencer and a 16-bit word memory port. At every instruction boundary the sequencer pulses a strobe and hands over its current code segment, instruction pointer, stack segment, stack pointer and flags word. The block then chooses one of three outcomes. If a halt has been requested, it stops and reports halted. If an interrupt is pending and allowed, it runs the real-mode entry sequence. Otherwise it passes the state through unchanged.

Interrupts are raised with a one-cycle strobe that carries an 8-bit vector. The vector is only acted on at a boundary, never in the middle of an instruction. Vectors 0 and 2 ignore the interrupt-enable flag. The entry sequence saves the flags, the code segment and the return offset on the stack. It loads the new code segment and offset from a 4-byte table entry at address vector*4 in low memory. It then clears the pending state. A one-cycle done pulse tells the sequencer that the new CS:IP and the matching 20-bit fetch address are valid.

Top module: `rm_irq_entry`

## Requirements
- R1: After synchronous reset, done_o, halted_o and mem_req_o are 0, and cs_o, ip_o, sp_o and flags_o are 0.
- R2: A raise strobe latches its 8-bit vector and marks it pending. No memory access starts until the next boundary strobe.
- R3: At a boundary the halt check comes first. If a halt was requested, halted_o rises and stays high until reset, and no memory access or done pulse follows, even when an interrupt is pending.
- R4: Vectors 0 and 2 are serviced at a boundary even when the interrupt-enable flag (flags bit 9) is 0.
- R5: Any other pending vector with flags bit 9 at 0 is not serviced. The boundary produces a done pulse with CS, IP, SP and flags copied unchanged, and the vector stays pending until a boundary with bit 9 set.
- R6: Service issues exactly five accesses in this order: write flags at SS*16+SP-2, write CS at SS*16+SP-4, read the new CS at vector*4+2, write IP at SS*16+SP-6, read the new IP at vector*4. Physical addresses wrap modulo 2^20.
- R7: The flags word pushed is the original value. flags_o after service equals it with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R8: After service, cs_o and ip_o hold the two table words, sp_o equals SP-6, and done_o is high for exactly one cycle. fetch_addr_o equals cs_o*16+ip_o modulo 2^20.
- R9: A serviced interrupt is no longer pending. The next boundary without a new raise passes the state through.
- R10: A memory request holds its address, direction and write data until mem_rdy_i is seen, for any number of wait cycles.
- R11: A raise that arrives while a service is running is kept pending and is serviced at a later boundary with its own vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 1 | One-cycle interrupt raise strobe |
| raise_vec_i | input | 8 | Vector number for the raise |
| halt_req_i | input | 1 | One-cycle halt request |
| boundary_i | input | 1 | Instruction boundary strobe from the sequencer |
| flags_i | input | 16 | Current flags word (bit 9 enable, bit 8 trap) |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| ss_i | input | 16 | Current stack segment |
| sp_i | input | 16 | Current stack pointer |
| cs_o | output | 16 | Code segment to resume with |
| ip_o | output | 16 | Instruction pointer to resume with |
| sp_o | output | 16 | Updated stack pointer |
| flags_o | output | 16 | Updated flags word |
| fetch_addr_o | output | 20 | Physical address of the next opcode fetch |
| done_o | output | 1 | One-cycle pulse: outputs valid, fetch may resume |
| halted_o | output | 1 | Block has stopped on a halt request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Physical byte address of the word access |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with mem_rdy_i |
| mem_rdy_i | input | 1 | Access completes on the edge where this is high |

## Verification
The hardest case to reach is a raise that lands while an earlier service is still moving through its five accesses. The pending flag is cleared on the same edge as the final table read, so the new raise must survive that clear without being overwritten. The bench reaches this by stretching every memory access with wait cycles. It then injects the second raise while the stack pushes are still stalled, and afterwards checks that the later boundary vectors through the second vector's table entry. A separate scenario combines a pending unmaskable vector with a halt request, to show that the halt check wins.

// File: rtl/rm_irq_pkg.sv
`timescale 1ns/1ps
package rm_irq_pkg;
  localparam int WORD_W = 16;
  localparam int SEG_SH = 4;
  localparam int ADDR_W = WORD_W + SEG_SH;
  localparam int VEC_W  = 8;
  localparam int IF_BIT = 9;
  localparam int TF_BIT = 8;
  localparam int PUSH_BYTES = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_LOAD_CS,
    ST_PUSH_IP,
    ST_LOAD_IP,
    ST_HALT
  } seq_state_t;

  function automatic logic [ADDR_W-1:0] phys(input logic [WORD_W-1:0] seg,
                                             input logic [WORD_W-1:0] off);
    logic [ADDR_W-1:0] base;
    base = {seg, {SEG_SH{1'b0}}};
    return base + {{SEG_SH{1'b0}}, off};
  endfunction
endpackage

// File: rtl/rm_irq_pending.sv
`timescale 1ns/1ps
module rm_irq_pending
  import rm_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             raise_i,
  input  logic [VEC_W-1:0] raise_vec_i,
  input  logic             halt_req_i,
  input  logic             busy_i,
  input  logic             clr_i,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             hpend_o
);
  logic raised_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o      <= 1'b0;
      vec_o       <= '0;
      hpend_o     <= 1'b0;
      raised_busy <= 1'b0;
    end else begin
      if (raise_i) begin
        vec_o <= raise_vec_i;
      end
      if (raise_i) begin
        pend_o <= 1'b1;
      end else if (clr_i) begin
        pend_o <= raised_busy;
      end
      if (clr_i) begin
        raised_busy <= 1'b0;
      end else if (raise_i && busy_i) begin
        raised_busy <= 1'b1;
      end
      if (halt_req_i) begin
        hpend_o <= 1'b1;
      end
    end
  end

  AST_RAISE_LATCH: assert property (@(posedge clk) disable iff (rst)
    raise_i |=> (pend_o && vec_o == $past(raise_vec_i))); // R2
  AST_HALT_HELD: assert property (@(posedge clk) disable iff (rst)
    hpend_o |=> hpend_o); // R3
endmodule

// File: rtl/rm_irq_gate.sv
`timescale 1ns/1ps
module rm_irq_gate
  import rm_irq_pkg::*;
(
  input  logic             boundary_i,
  input  logic             hpend_i,
  input  logic             pend_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             if_flag_i,
  output logic             halt_go_o,
  output logic             svc_go_o,
  output logic             pass_go_o
);
  logic unmaskable;

  always_comb begin
    unmaskable = (vec_i == VEC_W'(0)) || (vec_i == VEC_W'(2));
    halt_go_o  = boundary_i && hpend_i;
    svc_go_o   = boundary_i && !hpend_i && pend_i && (unmaskable || if_flag_i);
    pass_go_o  = boundary_i && !hpend_i && !(pend_i && (unmaskable || if_flag_i));
  end
endmodule

// File: rtl/rm_irq_seq.sv
`timescale 1ns/1ps
module rm_irq_seq
  import rm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_go_i,
  input  logic              svc_go_i,
  input  logic              pass_go_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] flags_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              done_o,
  output logic              halted_o,
  output logic              idle_o,
  output logic              clr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i
);
  localparam int TBL_PAD = ADDR_W - VEC_W - 2;

  seq_state_t        st;
  logic [WORD_W-1:0] cs_r, ip_r, sp_r, ss_r, flags_r;
  logic [VEC_W-1:0]  vec_r;
  logic              done_r;
  logic              step;

  assign step = mem_req_o && mem_rdy_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = phys(ss_r, sp_r);
    mem_wdata_o = flags_r;
    unique case (st)
      ST_PUSH_FL: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = flags_r; end
      ST_PUSH_CS: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = cs_r; end
      ST_PUSH_IP: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = ip_r; end
      ST_LOAD_CS: begin mem_req_o = 1'b1; mem_addr_o = {{TBL_PAD{1'b0}}, vec_r, 2'b10}; end
      ST_LOAD_IP: begin mem_req_o = 1'b1; mem_addr_o = {{TBL_PAD{1'b0}}, vec_r, 2'b00}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cs_r    <= '0;
      ip_r    <= '0;
      sp_r    <= '0;
      ss_r    <= '0;
      flags_r <= '0;
      vec_r   <= '0;
      done_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (halt_go_i) begin
            st <= ST_HALT;
          end else if (svc_go_i) begin
            cs_r    <= cs_i;
            ip_r    <= ip_i;
            ss_r    <= ss_i;
            sp_r    <= sp_i - WORD_W'(PUSH_BYTES);
            flags_r <= flags_i;
            vec_r   <= vec_i;
            st      <= ST_PUSH_FL;
          end else if (pass_go_i) begin
            cs_r    <= cs_i;
            ip_r    <= ip_i;
            ss_r    <= ss_i;
            sp_r    <= sp_i;
            flags_r <= flags_i;
            done_r  <= 1'b1;
          end
        end
        ST_PUSH_FL: if (step) begin
          flags_r[IF_BIT] <= 1'b0;
          flags_r[TF_BIT] <= 1'b0;
          sp_r <= sp_r - WORD_W'(PUSH_BYTES);
          st   <= ST_PUSH_CS;
        end
        ST_PUSH_CS: if (step) begin
          sp_r <= sp_r - WORD_W'(PUSH_BYTES);
          st   <= ST_LOAD_CS;
        end
        ST_LOAD_CS: if (step) begin
          cs_r <= mem_rdata_i;
          st   <= ST_PUSH_IP;
        end
        ST_PUSH_IP: if (step) begin
          st <= ST_LOAD_IP;
        end
        ST_LOAD_IP: if (step) begin
          ip_r   <= mem_rdata_i;
          done_r <= 1'b1;
          st     <= ST_IDLE;
        end
        ST_HALT: st <= ST_HALT;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cs_o         = cs_r;
  assign ip_o         = ip_r;
  assign sp_o         = sp_r;
  assign flags_o      = flags_r;
  assign fetch_addr_o = phys(cs_r, ip_r);
  assign done_o       = done_r;
  assign halted_o     = (st == ST_HALT);
  assign idle_o       = (st == ST_IDLE);
  assign clr_o        = (st == ST_LOAD_IP) && step;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mem_req_o); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o); // R3
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> (!mem_req_o && !done_o)); // R3
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD_IP) |-> (!flags_r[IF_BIT] && !flags_r[TF_BIT])); // R7
endmodule

// File: rtl/rm_irq_entry.sv
`timescale 1ns/1ps
module rm_irq_entry
  import rm_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_i,
  input  logic [VEC_W-1:0]  raise_vec_i,
  input  logic              halt_req_i,
  input  logic              boundary_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] flags_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              done_o,
  output logic              halted_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i
);
  logic             pend, hpend, idle, clr;
  logic [VEC_W-1:0] vec;
  logic             halt_go, svc_go, pass_go;
  logic             bnd_ok;

  assign bnd_ok = boundary_i && idle;

  rm_irq_pending u_pending (
    .clk         (clk),
    .rst         (rst),
    .raise_i     (raise_i),
    .raise_vec_i (raise_vec_i),
    .halt_req_i  (halt_req_i),
    .busy_i      (!idle),
    .clr_i       (clr),
    .pend_o      (pend),
    .vec_o       (vec),
    .hpend_o     (hpend)
  );

  rm_irq_gate u_gate (
    .boundary_i (bnd_ok),
    .hpend_i    (hpend),
    .pend_i     (pend),
    .vec_i      (vec),
    .if_flag_i  (flags_i[IF_BIT]),
    .halt_go_o  (halt_go),
    .svc_go_o   (svc_go),
    .pass_go_o  (pass_go)
  );

  rm_irq_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .halt_go_i    (halt_go),
    .svc_go_i     (svc_go),
    .pass_go_i    (pass_go),
    .vec_i        (vec),
    .flags_i      (flags_i),
    .cs_i         (cs_i),
    .ip_i         (ip_i),
    .ss_i         (ss_i),
    .sp_i         (sp_i),
    .cs_o         (cs_o),
    .ip_o         (ip_o),
    .sp_o         (sp_o),
    .flags_o      (flags_o),
    .fetch_addr_o (fetch_addr_o),
    .done_o       (done_o),
    .halted_o     (halted_o),
    .idle_o       (idle),
    .clr_o        (clr),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_rdy_i    (mem_rdy_i)
  );

  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (rst)
    (idle && !svc_go) |=> !mem_req_o); // R2
endmodule

// File: tb/test_rm_irq_entry.sv
`timescale 1ns/1ps
module test_rm_irq_entry;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        raise = 1'b0;
  logic [7:0]  rvec = '0;
  logic        halt_req = 1'b0;
  logic        bnd = 1'b0;
  logic [15:0] flags = '0, cs = '0, ip = '0, ss = '0, sp = '0;
  logic [15:0] cs_o, ip_o, sp_o, flags_o;
  logic [19:0] fetch_addr;
  logic        done, halted;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rdy = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  int lat = 0;
  int cnt = 0;
  int lg_n = 0;
  logic        lg_we   [64];
  logic [19:0] lg_addr [64];
  logic [15:0] lg_data [64];

  always #10 clk = ~clk;

  rm_irq_entry i_rm_irq_entry (
    .clk(clk), .rst(rst), .raise_i(raise), .raise_vec_i(rvec),
    .halt_req_i(halt_req), .boundary_i(bnd), .flags_i(flags),
    .cs_i(cs), .ip_i(ip), .ss_i(ss), .sp_i(sp),
    .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o), .flags_o(flags_o),
    .fetch_addr_o(fetch_addr), .done_o(done), .halted_o(halted),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy)
  );

  function automatic logic [19:0] ph(input logic [15:0] s, input logic [15:0] o);
    return ({s, 4'h0} + {4'h0, o});
  endfunction

  function automatic logic [15:0] tbl(input logic [19:0] a);
    logic [19:0] t;
    t = a * 20'd13 + 20'h00451;
    return t[15:0];
  endfunction

  // Memory model: answers after `lat` wait cycles, logs every access.
  always @(negedge clk) begin
    if (rst || !mem_req) begin
      mem_rdy = 1'b0;
      cnt = 0;
    end else if (cnt >= lat) begin
      mem_rdy = 1'b1;
      mem_rdata = mem_we ? 16'hDEAD : tbl(mem_addr);
      if (lg_n < 64) begin
        lg_we[lg_n] = mem_we;
        lg_addr[lg_n] = mem_addr;
        lg_data[lg_n] = mem_wdata;
      end
      lg_n = lg_n + 1;
      cnt = 0;
    end else begin
      mem_rdy = 1'b0;
      cnt = cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic raise_vec(input logic [7:0] v);
    raise = 1'b1; rvec = v;
    @(negedge clk);
    raise = 1'b0;
  endtask

  task automatic pulse_bnd();
    bnd = 1'b1;
    @(negedge clk);
    bnd = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic set_state(input logic [15:0] f, c, i, s, p);
    flags = f; cs = c; ip = i; ss = s; sp = p;
  endtask

  // Boundary with an expected full service of vector v.
  task automatic expect_service(input logic [7:0] v, input string req);
    bit got;
    int base;
    logic [19:0] tcs, tip;
    logic [15:0] ecs, eip;
    base = lg_n;
    tcs = {10'h0, v, 2'b10};
    tip = {10'h0, v, 2'b00};
    ecs = tbl(tcs);
    eip = tbl(tip);
    pulse_bnd();
    wait_done(got);
    check(got, req, 32'(got), 1, "done pulse after service");
    check(lg_n - base == 5, "R6", 32'(lg_n - base), 5, "access count");
    check(lg_we[base] && lg_addr[base] == ph(ss, sp - 16'd2) && lg_data[base] == flags,
          "R6", {lg_addr[base][15:0], lg_data[base]}, {ph(ss, sp - 16'd2)}[15:0] << 16 | flags, "flags push");
    check(lg_data[base] == flags, "R7", 32'(lg_data[base]), 32'(flags), "pushed flags unchanged");
    check(lg_we[base+1] && lg_addr[base+1] == ph(ss, sp - 16'd4) && lg_data[base+1] == cs,
          "R6", 32'(lg_addr[base+1]), 32'(ph(ss, sp - 16'd4)), "CS push");
    check(!lg_we[base+2] && lg_addr[base+2] == tcs, "R6", 32'(lg_addr[base+2]), 32'(tcs), "CS table read");
    check(lg_we[base+3] && lg_addr[base+3] == ph(ss, sp - 16'd6) && lg_data[base+3] == ip,
          "R6", 32'(lg_addr[base+3]), 32'(ph(ss, sp - 16'd6)), "IP push");
    check(!lg_we[base+4] && lg_addr[base+4] == tip, "R6", 32'(lg_addr[base+4]), 32'(tip), "IP table read");
    check(cs_o == ecs && ip_o == eip, "R8", {cs_o, ip_o}, {ecs, eip}, "new CS:IP");
    check(sp_o == sp - 16'd6, "R8", 32'(sp_o), 32'(sp - 16'd6), "stack pointer");
    check(fetch_addr == ph(ecs, eip), "R8", 32'(fetch_addr), 32'(ph(ecs, eip)), "fetch address");
    check(flags_o == (flags & 16'hFCFF), "R7", 32'(flags_o), 32'(flags & 16'hFCFF), "IF/TF cleared");
    @(negedge clk);
    check(!done, "R8", 32'(done), 0, "done lasts one cycle");
  endtask

  // Boundary with an expected pass-through.
  task automatic expect_pass(input string req);
    bit got;
    int base;
    base = lg_n;
    pulse_bnd();
    wait_done(got);
    check(got, req, 32'(got), 1, "done pulse on pass");
    check(lg_n == base, req, 32'(lg_n - base), 0, "no memory access on pass");
    check(cs_o == cs && ip_o == ip && sp_o == sp && flags_o == flags, req,
          {cs_o, ip_o}, {cs, ip}, "state unchanged on pass");
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(!done && !halted && !mem_req, "R1", {29'h0, done, halted, mem_req}, 0, "control outputs");
    check(cs_o == 0 && ip_o == 0 && sp_o == 0 && flags_o == 0, "R1", {cs_o, ip_o}, 0, "state outputs");
  endtask

  task automatic t_no_early();
    bit seen;
    lat = 0;
    set_state(16'h0302, 16'h1234, 16'h0100, 16'h2000, 16'h0800);
    raise_vec(8'h21);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (mem_req) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R2", 32'(seen), 0, "no access before boundary");
    expect_service(8'h21, "R2");
  endtask

  task automatic t_wait_wrap();
    lat = 3;
    set_state(16'h0200, 16'hF000, 16'hFFF0, 16'hFFFF, 16'h0003);
    raise_vec(8'h10);
    expect_service(8'h10, "R10");
    lat = 0;
  endtask

  task automatic t_clear();
    set_state(16'h0200, 16'h0040, 16'h0010, 16'h3000, 16'h0100);
    expect_pass("R9");
  endtask

  task automatic t_masked();
    set_state(16'h0100, 16'h0ABC, 16'h0042, 16'h1000, 16'h0200);
    raise_vec(8'h30);
    expect_pass("R5");
    flags = 16'h0200;
    expect_service(8'h30, "R5");
  endtask

  task automatic t_unmaskable();
    set_state(16'h0100, 16'h0700, 16'h0007, 16'h0900, 16'h0400);
    raise_vec(8'h02);
    expect_service(8'h02, "R4");
    set_state(16'h0000, 16'h0701, 16'h0008, 16'h0900, 16'h0300);
    raise_vec(8'h00);
    expect_service(8'h00, "R4");
  endtask

  task automatic t_rearm();
    bit got;
    lat = 2;
    set_state(16'h0200, 16'h5000, 16'h0020, 16'h0600, 16'h0500);
    raise_vec(8'h11);
    pulse_bnd();
    repeat (3) @(negedge clk);
    raise_vec(8'h44);
    wait_done(got);
    check(got, "R11", 32'(got), 1, "first service completes");
    check(ip_o == tbl({10'h0, 8'h11, 2'b00}), "R11", 32'(ip_o),
          32'(tbl({10'h0, 8'h11, 2'b00})), "first service used first vector");
    @(negedge clk);
    set_state(16'h0200, 16'h5100, 16'h0030, 16'h0600, 16'h0480);
    expect_service(8'h44, "R11");
    lat = 0;
  endtask

  task automatic t_halt();
    bit seen;
    int base;
    base = lg_n;
    set_state(16'h0200, 16'h0100, 16'h0000, 16'h0100, 16'h0100);
    raise_vec(8'h00);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    pulse_bnd();
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (done) seen = 1;
      @(negedge clk);
    end
    check(halted, "R3", 32'(halted), 1, "halted after boundary");
    check(!seen && lg_n == base, "R3", 32'(lg_n - base), 0, "no access or done when halted");
    pulse_bnd();
    repeat (3) @(negedge clk);
    check(halted && !done && lg_n == base, "R3", 32'(halted), 1, "halt persists over boundary");
    do_reset();
    check(!halted, "R1", 32'(halted), 0, "reset leaves halted state");
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_no_early();
    t_wait_wrap();
    t_clear();
    t_masked();
    t_unmaskable();
    t_rearm();
    t_halt();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule